// File: doc/BRIEF.md
# SPI Calendar Clock Slave

This block is the slave side of a serial calendar clock. It keeps seconds, minutes, hours, weekday, day, month and year as BCD bytes. A one-cycle tick input, prescaled to one second elsewhere, advances them with full carry handling: month lengths, leap years, the century flag and both hour encodings. A host master reaches the registers over a four-wire serial link. The link runs in mode 1 with an active-high select and sends the most significant bit first.

Every transfer opens with a command byte. The high nibble of that byte is a start address and two mode bits pick read or write and single or burst. Burst transfers step the address after each data byte, so one select window can move the whole time set. A burst read returns a copy of the time taken when select rises, so a carry during the read cannot tear the value. While a burst write is in progress, ticks are discarded. The serial inputs are resynchronised to the core clock, so the serial clock must be several times slower than `clk`.

Top module: `spi_rtc_slave`

## Requirements
- R1: The command byte carries the start address in bits 7:4. Bit 3 selects single (1) or burst (0) and bit 2 selects read (1) or write (0). Bits 1:0 are ignored.
- R2: The link uses mode 1 with an active-high select. MISO changes after a rising SCK and MOSI is taken on a falling SCK, MSB first. MISO is 0 while the select is low and during the command byte.
- R3: The register addresses are seconds 0, minutes 1, hours 2, weekday 3, day 4, month 5, year 6, mode control 14 (bit 5 = 24-hour) and status control 15 (bit 4 = oscillator stopped). Writes are masked per field: 0x7F, 0x7F, 0x3F, 0x07, 0x3F, 0x9F and 0xFF for addresses 0 to 6. Controls keep only their named bit. All other addresses read 0 and ignore writes.
- R4: In burst mode the address rises by one after each data byte and wraps from 15 to 0.
- R5: A single transfer moves exactly one data byte. Later bytes in the same window read as 0 and are not written.
- R6: After reset the time bytes are 0x00, except day and month, which are 0x01. The 24-hour bit is 0, the stopped flag is 1 and MISO is 0.
- R7: Each accepted tick adds one to the BCD seconds. 59 wraps to 00 and carries into the minutes, which wrap the same way and carry into the hours.
- R8: In 24-hour mode hours run 00..23. In 12-hour mode hours run 12,01..11 with bit 5 as PM. 11 AM becomes 12 PM, and 11 PM becomes 12 AM with a carry to the day. A change of mode does not rewrite the hour byte.
- R9: A day carry steps the weekday 0..6 and the day. Day 1 follows the last day of the month: 28 or 29 in February, where leap years are the years divisible by 4, 30 in April, June, September and November, and 31 otherwise. Month 12 wraps to 1 and steps the year. Year 99 wraps to 00 and toggles month bit 7.
- R10: While the stopped flag is 1, ticks have no effect. A write to address 15 loads the flag from bit 4 of the data, so writing 0 restarts counting.
- R11: All reads in a window return time bytes as they stood when the select rose, even if a tick lands during the transfer.
- R12: A tick that arrives during a burst write, after its command byte, is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle time-advance pulse |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_cs | input | 1 | Slave select, active high |
| spi_mosi | input | 1 | Serial data into the slave |
| spi_miso | output | 1 | Serial data out of the slave |

## Verification
The assertions check four things on every cycle:
- MISO stays quiet while deselected.
- Each serial byte causes at most one register write.
- The seconds byte holds through a discarded tick, whether the oscillator is stopped or a burst write is in progress.
- Every accepted tick changes the seconds, and the hour mode changes only through its own register.

Only the bench's scenarios can show the calendar results: the 12-hour and 24-hour rollovers, the leap-year and century rules, address wrap and single-transfer truncation. The same holds for snapshot consistency across a mid-read tick. Each of these is compared against a reference model computed from binary time values.

// File: rtl/spi_rtc_pkg.sv
`timescale 1ns/1ps
package spi_rtc_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int N_TIME    = 7;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_WDAY = 3;
  localparam int IDX_DAY  = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;

  localparam logic [ADDR_W-1:0] A_MODE   = 4'd14;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd15;

  localparam int PM_BIT   = 5;
  localparam int CENT_BIT = 7;
  localparam int H24_BIT  = 5;
  localparam int STOP_BIT = 4;

  // year, month, day, weekday, hour, minute, second
  localparam logic [N_TIME*BYTE_W-1:0] TIME_RST = 56'h00_01_01_00_00_00_00;

  typedef logic [BYTE_W-1:0] rbyte_t;

  // {single, read}
  typedef enum logic [1:0] {
    XM_BURST_WR  = 2'b00,
    XM_BURST_RD  = 2'b01,
    XM_SINGLE_WR = 2'b10,
    XM_SINGLE_RD = 2'b11
  } xfer_mode_t;

  function automatic rbyte_t bcd_inc(rbyte_t v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return v + 8'h01;
  endfunction

  function automatic rbyte_t field_mask(int idx);
    case (idx)
      IDX_SEC, IDX_MIN: return 8'h7F;
      IDX_HOUR, IDX_DAY: return 8'h3F;
      IDX_WDAY: return 8'h07;
      IDX_MON:  return 8'h9F;
      default:  return 8'hFF;
    endcase
  endfunction

  // last day of a BCD month; tens*10 is congruent to tens*2 modulo 4
  function automatic rbyte_t last_day(logic [4:0] mon, rbyte_t yr);
    logic [3:0] m4;
    m4 = {2'b00, yr[4], 1'b0} + yr[3:0];
    case (mon)
      5'h02: return (m4[1:0] == 2'b00) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/spi_rtc_shifter.sv
`timescale 1ns/1ps
module spi_rtc_shifter
  import spi_rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sck,
  input  logic   cs,
  input  logic   mosi,
  input  rbyte_t tx_byte,
  output logic   sel,
  output logic   sel_rise,
  output logic   byte_done,
  output rbyte_t rx_byte,
  output logic   miso
);
  logic [SYNC_STAGES-1:0] sck_sr, cs_sr, mosi_sr;
  logic sck_prev, sel_prev;
  logic sck_s, mosi_s, edge_rise, edge_fall;
  logic [BIT_CNT_W-1:0] bit_cnt_q, bit_cnt_d;
  logic [BYTE_W-2:0] rx_sh_q, rx_sh_d;
  rbyte_t tx_sh_q, tx_sh_d;
  logic miso_q, miso_d;

  assign sck_s  = sck_sr[SYNC_STAGES-1];
  assign sel    = cs_sr[SYNC_STAGES-1];
  assign mosi_s = mosi_sr[SYNC_STAGES-1];

  assign edge_rise = sel & sck_s & ~sck_prev;
  assign edge_fall = sel & ~sck_s & sck_prev;
  assign sel_rise  = sel & ~sel_prev;
  assign rx_byte   = {rx_sh_q, mosi_s};
  assign byte_done = edge_fall && (bit_cnt_q == BIT_CNT_W'(BYTE_W-1));
  assign miso      = miso_q;

  always_comb begin
    bit_cnt_d = bit_cnt_q;
    rx_sh_d   = rx_sh_q;
    tx_sh_d   = tx_sh_q;
    miso_d    = miso_q;
    if (!sel) begin
      bit_cnt_d = '0;
      tx_sh_d   = '0;
      miso_d    = 1'b0;
    end else if (edge_fall) begin
      rx_sh_d   = rx_byte[BYTE_W-2:0];
      bit_cnt_d = bit_cnt_q + 1'b1;
      if (byte_done) tx_sh_d = tx_byte;
    end else if (edge_rise) begin
      miso_d  = tx_sh_q[BYTE_W-1];
      tx_sh_d = {tx_sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sr    <= '0;
      cs_sr     <= '0;
      mosi_sr   <= '0;
      sck_prev  <= 1'b0;
      sel_prev  <= 1'b0;
      bit_cnt_q <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      miso_q    <= 1'b0;
    end else begin
      sck_sr    <= {sck_sr[SYNC_STAGES-2:0], sck};
      cs_sr     <= {cs_sr[SYNC_STAGES-2:0], cs};
      mosi_sr   <= {mosi_sr[SYNC_STAGES-2:0], mosi};
      sck_prev  <= sck_s;
      sel_prev  <= sel;
      bit_cnt_q <= bit_cnt_d;
      rx_sh_q   <= rx_sh_d;
      tx_sh_q   <= tx_sh_d;
      miso_q    <= miso_d;
    end
  end
endmodule

// File: rtl/spi_rtc_cmd.sv
`timescale 1ns/1ps
module spi_rtc_cmd
  import spi_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              byte_done,
  input  rbyte_t            rx_byte,
  input  rbyte_t            rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output rbyte_t            tx_byte,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output rbyte_t            wr_data,
  output logic              burst_wr
);
  logic have_cmd_q, have_cmd_d;
  logic done_q, done_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  xfer_mode_t mode_q, mode_d;
  logic mode_single, mode_read;

  assign mode_single = mode_q[1];
  assign mode_read   = mode_q[0];
  assign wr_addr     = addr_q;
  assign wr_data     = rx_byte;
  assign wr_en       = byte_done && have_cmd_q && !done_q && !mode_read;
  assign burst_wr    = sel && have_cmd_q && (mode_q == XM_BURST_WR);

  // data for the byte that starts after the current one completes
  always_comb begin
    if (!have_cmd_q) begin
      rd_addr = rx_byte[BYTE_W-1 -: ADDR_W];
      tx_byte = rx_byte[2] ? rd_data : '0;
    end else begin
      rd_addr = addr_q + 1'b1;
      tx_byte = (mode_read && !mode_single && !done_q) ? rd_data : '0;
    end
  end

  always_comb begin
    have_cmd_d = have_cmd_q;
    done_d     = done_q;
    addr_d     = addr_q;
    mode_d     = mode_q;
    if (!sel) begin
      have_cmd_d = 1'b0;
      done_d     = 1'b0;
      addr_d     = '0;
      mode_d     = XM_BURST_WR;
    end else if (byte_done) begin
      if (!have_cmd_q) begin
        have_cmd_d = 1'b1;
        addr_d     = rx_byte[BYTE_W-1 -: ADDR_W];
        mode_d     = xfer_mode_t'(rx_byte[3:2]);
      end else if (!done_q) begin
        if (mode_single) done_d = 1'b1;
        else             addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_cmd_q <= 1'b0;
      done_q     <= 1'b0;
      addr_q     <= '0;
      mode_q     <= XM_BURST_WR;
    end else begin
      have_cmd_q <= have_cmd_d;
      done_q     <= done_d;
      addr_q     <= addr_d;
      mode_q     <= mode_d;
    end
  end
endmodule

// File: rtl/spi_rtc_calendar.sv
`timescale 1ns/1ps
module spi_rtc_calendar
  import spi_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_tick,
  input  logic              snap_take,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  rbyte_t            wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output rbyte_t            rd_data,
  output logic              stop_flag,
  output logic              hour24,
  output rbyte_t            sec_out
);
  logic [N_TIME-1:0][BYTE_W-1:0] time_q, time_d, snap_q, snap_d, tk;
  logic h24_q, h24_d, stop_q, stop_d;
  logic adv;
  logic c_sec, c_min, c_hr, c_day, c_mon, c_yr;
  rbyte_t hr, hr_inc;

  assign adv       = tick & ~stop_q & ~hold_tick & ~wr_en;
  assign stop_flag = stop_q;
  assign hour24    = h24_q;
  assign sec_out   = time_q[IDX_SEC];

  // one-second advance with carry chain
  always_comb begin
    tk     = time_q;
    hr     = time_q[IDX_HOUR];
    hr_inc = bcd_inc({3'b000, hr[4:0]});
    c_hr   = 1'b0;
    c_sec  = (time_q[IDX_SEC] == 8'h59);
    tk[IDX_SEC] = c_sec ? 8'h00 : bcd_inc(time_q[IDX_SEC]);
    c_min = c_sec && (time_q[IDX_MIN] == 8'h59);
    if (c_sec) tk[IDX_MIN] = (time_q[IDX_MIN] == 8'h59) ? 8'h00 : bcd_inc(time_q[IDX_MIN]);
    if (c_min) begin
      if (h24_q) begin
        c_hr = (hr == 8'h23);
        tk[IDX_HOUR] = c_hr ? 8'h00 : bcd_inc(hr);
      end else if (hr[4:0] == 5'h11) begin
        c_hr = hr[PM_BIT];
        tk[IDX_HOUR] = {2'b00, ~hr[PM_BIT], 5'h12};
      end else if (hr[4:0] == 5'h12) begin
        tk[IDX_HOUR] = {2'b00, hr[PM_BIT], 5'h01};
      end else begin
        tk[IDX_HOUR] = {2'b00, hr[PM_BIT], hr_inc[4:0]};
      end
    end
    c_day = c_hr && (time_q[IDX_DAY] == last_day(time_q[IDX_MON][4:0], time_q[IDX_YEAR]));
    c_mon = c_day && (time_q[IDX_MON][4:0] == 5'h12);
    c_yr  = c_mon && (time_q[IDX_YEAR] == 8'h99);
    if (c_hr) begin
      tk[IDX_WDAY] = (time_q[IDX_WDAY] >= 8'h06) ? 8'h00 : time_q[IDX_WDAY] + 8'h01;
      tk[IDX_DAY]  = c_day ? 8'h01 : bcd_inc(time_q[IDX_DAY]);
    end
    if (c_day) begin
      tk[IDX_MON][4:0] = c_mon ? 5'h01 : bcd_inc({3'b000, time_q[IDX_MON][4:0]})[4:0];
    end
    if (c_mon) tk[IDX_YEAR] = c_yr ? 8'h00 : bcd_inc(time_q[IDX_YEAR]);
    if (c_yr)  tk[IDX_MON][CENT_BIT] = ~time_q[IDX_MON][CENT_BIT];
  end

  always_comb begin
    time_d = adv ? tk : time_q;
    for (int i = 0; i < N_TIME; i++) begin
      if (wr_en && (wr_addr == ADDR_W'(i))) time_d[i] = wr_data & field_mask(i);
    end
    h24_d  = (wr_en && wr_addr == A_MODE)   ? wr_data[H24_BIT]  : h24_q;
    stop_d = (wr_en && wr_addr == A_STATUS) ? wr_data[STOP_BIT] : stop_q;
    snap_d = snap_take ? time_q : snap_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_TIME; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = snap_q[i];
    end
    if (rd_addr == A_MODE)   rd_data[H24_BIT]  = h24_q;
    if (rd_addr == A_STATUS) rd_data[STOP_BIT] = stop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= TIME_RST;
      snap_q <= TIME_RST;
      h24_q  <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      time_q <= time_d;
      snap_q <= snap_d;
      h24_q  <= h24_d;
      stop_q <= stop_d;
    end
  end
endmodule

// File: rtl/spi_rtc_slave.sv
`timescale 1ns/1ps
module spi_rtc_slave
  import spi_rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1hz,
  input  logic spi_sck,
  input  logic spi_cs,
  input  logic spi_mosi,
  output logic spi_miso
);
  logic sel_s, sel_rise, byte_done, wr_en, burst_wr, stop_flag, hour24;
  rbyte_t rx_byte, tx_byte, rd_data, wr_data, sec_now;
  logic [ADDR_W-1:0] rd_addr, wr_addr;

  spi_rtc_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs(spi_cs), .mosi(spi_mosi),
    .tx_byte(tx_byte), .sel(sel_s), .sel_rise(sel_rise), .byte_done(byte_done),
    .rx_byte(rx_byte), .miso(spi_miso)
  );

  spi_rtc_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .sel(sel_s), .byte_done(byte_done),
    .rx_byte(rx_byte), .rd_data(rd_data), .rd_addr(rd_addr), .tx_byte(tx_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .burst_wr(burst_wr)
  );

  spi_rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .hold_tick(burst_wr),
    .snap_take(sel_rise), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .stop_flag(stop_flag),
    .hour24(hour24), .sec_out(sec_now)
  );
endmodule

// File: rtl/spi_rtc_checker.sv
`timescale 1ns/1ps
module spi_rtc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       miso,
  input logic       tick,
  input logic       hold,
  input logic       stop,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [7:0] sec,
  input logic       h24
);
  a_r2_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !miso);

  a_r5_one_write_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  a_r10_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_en) |=> $stable(sec));

  a_r12_tick_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hold && !wr_en) |=> $stable(sec));

  a_r7_tick_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && !hold && !wr_en) |=> (sec != $past(sec)));

  a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 4'd14) |=> $stable(h24));
endmodule

bind spi_rtc_slave spi_rtc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel_s), .miso(spi_miso), .tick(tick_1hz),
  .hold(burst_wr), .stop(stop_flag), .wr_en(wr_en), .wr_addr(wr_addr),
  .sec(sec_now), .h24(hour24)
);

// File: tb/sim_spi_rtc_slave.sv
`timescale 1ns/1ps
module sim_spi_rtc_slave;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n, tick, sck, cs, mosi;
  wire  miso;
  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m [16];
  logic [7:0] wbuf [16];
  logic [7:0] tx_buf [17];
  logic [7:0] rx_buf [17];
  logic [7:0] expv [16];

  always #2.5 clk = ~clk;

  spi_rtc_slave u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .spi_sck(sck),
    .spi_cs(cs), .spi_mosi(mosi), .spi_miso(miso)
  );

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] i2b(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int b2i(logic [7:0] x);
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] wmask(int a);
    case (a)
      0, 1: return 8'h7F;
      2, 4: return 8'h3F;
      3: return 8'h07;
      5: return 8'h9F;
      6: return 8'hFF;
      14: return 8'h20;
      15: return 8'h10;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    return m[a] & wmask(a);
  endfunction

  task automatic model_write(int a, logic [7:0] d);
    m[a] = d & wmask(a);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m[i] = 8'h00;
    m[4] = 8'h01; m[5] = 8'h01; m[15] = 8'h10;
  endtask

  task automatic model_tick();
    int s, mi, h, wd, d, mo, y;
    logic c;
    if (m[15][4]) return;
    s = b2i(m[0]); mi = b2i(m[1]); wd = int'(m[3]); d = b2i(m[4]);
    mo = b2i(m[5] & 8'h1F); y = b2i(m[6]); c = m[5][7];
    if (m[14][5]) h = b2i(m[2]);
    else h = (b2i(m[2] & 8'h1F) % 12) + (m[2][5] ? 12 : 0);
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0; wd = (wd == 6) ? 0 : wd + 1; d++;
          if (d > mdays(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin
              mo = 1; y++;
              if (y == 100) begin y = 0; c = ~c; end
            end
          end
        end
      end
    end
    m[0] = i2b(s); m[1] = i2b(mi); m[3] = 8'(wd); m[4] = i2b(d);
    m[5] = {c, 2'b00, i2b(mo)[4:0]}; m[6] = i2b(y);
    if (m[14][5]) m[2] = i2b(h);
    else m[2] = ((h >= 12) ? 8'h20 : 8'h00) | i2b((h + 11) % 12 + 1);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic tick_model();
    pulse_tick();
    model_tick();
    clks(2);
  endtask

  // one select window of nb bytes; optional tick after byte index tick_after
  task automatic xfer(int nb, int tick_after);
    @(negedge clk) cs = 1'b1;
    clks(6);
    for (int i = 0; i < nb; i++) begin
      for (int b = 7; b >= 0; b--) begin
        @(negedge clk);
        sck = 1'b1; mosi = tx_buf[i][b];
        clks(HALF);
        rx_buf[i][b] = miso;
        sck = 1'b0;
        clks(HALF);
      end
      if (i == tick_after) pulse_tick();
    end
    clks(6);
    cs = 1'b0; mosi = 1'b0;
    clks(6);
  endtask

  task automatic do_write(int a, bit single, int n, int tick_after);
    tx_buf[0] = {4'(a), single, 3'b000};
    for (int i = 0; i < n; i++) tx_buf[i + 1] = wbuf[i];
    xfer(n + 1, tick_after);
    for (int i = 0; i < n; i++)
      if (!single || i == 0) model_write((a + i) % 16, wbuf[i]);
  endtask

  task automatic do_read(int a, bit single, int n, int tick_after, string req,
                         logic [1:0] low = 2'b00);
    for (int i = 0; i < n; i++)
      expv[i] = (single && i > 0) ? 8'h00 : exp_rd((a + i) % 16);
    tx_buf[0] = {4'(a), single, 1'b1, low};
    for (int i = 1; i <= n; i++) tx_buf[i] = 8'($urandom);
    xfer(n + 1, tick_after);
    if (tick_after >= 0) model_tick();
    chk("R2", rx_buf[0], 8'h00);
    for (int i = 0; i < n; i++) chk(req, rx_buf[i + 1], expv[i]);
  endtask

  task automatic single_write(int a, logic [7:0] d);
    wbuf[0] = d;
    do_write(a, 1'b1, 1, -1);
  endtask

  task automatic load_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                           logic [7:0] wd, logic [7:0] d, logic [7:0] mo,
                           logic [7:0] y);
    wbuf[0] = s; wbuf[1] = mi; wbuf[2] = h; wbuf[3] = wd;
    wbuf[4] = d; wbuf[5] = mo; wbuf[6] = y;
    do_write(0, 1'b0, 7, -1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst_n = 1'b0; tick = 1'b0; sck = 1'b0; cs = 1'b0; mosi = 1'b0;
    model_reset();
    clks(5);
    chk("R6", {7'd0, miso}, 8'h00);
    rst_n = 1'b1;
    clks(5);

    // R6: reset contents
    do_read(0, 1'b0, 7, -1, "R6");
    do_read(14, 1'b0, 2, -1, "R6");

    // R10: stopped oscillator ignores ticks, write 0 restarts
    tick_model();
    do_read(0, 1'b0, 1, -1, "R10");
    single_write(15, 8'h00);
    do_read(15, 1'b1, 1, -1, "R10");
    tick_model();
    do_read(0, 1'b0, 1, -1, "R10");

    // R9: full rollover in 24-hour mode, century toggles
    single_write(14, 8'h20);
    load_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    tick_model();
    do_read(0, 1'b0, 7, -1, "R9");
    chk("R9", m[5], 8'h81);

    // R9: leap year handling
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    tick_model();
    do_read(0, 1'b0, 7, -1, "R9");
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24);
    tick_model();
    do_read(0, 1'b0, 7, -1, "R9");
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    tick_model();
    do_read(0, 1'b0, 7, -1, "R9");

    // R7: BCD digit and minute carry
    load_time(8'h09, 8'h12, 8'h05, 8'h01, 8'h10, 8'h05, 8'h30);
    tick_model();
    do_read(0, 1'b0, 2, -1, "R7");
    load_time(8'h59, 8'h12, 8'h05, 8'h01, 8'h10, 8'h05, 8'h30);
    tick_model();
    do_read(0, 1'b0, 3, -1, "R7");

    // R8: 12-hour mode transitions
    single_write(14, 8'h00);
    load_time(8'h59, 8'h59, 8'h11, 8'h02, 8'h15, 8'h03, 8'h10);
    tick_model();
    do_read(0, 1'b0, 7, -1, "R8");
    chk("R8", m[2], 8'h32);
    load_time(8'h59, 8'h59, 8'h31, 8'h02, 8'h15, 8'h03, 8'h10);
    tick_model();
    do_read(0, 1'b0, 7, -1, "R8");
    chk("R8", m[4], 8'h16);
    load_time(8'h59, 8'h59, 8'h12, 8'h02, 8'h15, 8'h03, 8'h10);
    tick_model();
    do_read(2, 1'b1, 1, -1, "R8");

    // R4: burst wrap from 15 to 0
    do_read(14, 1'b0, 4, -1, "R4");
    wbuf[0] = 8'h00; wbuf[1] = 8'h45; wbuf[2] = 8'h33;
    do_write(15, 1'b0, 3, -1);
    do_read(0, 1'b0, 2, -1, "R4");

    // R3: unimplemented addresses and field masks
    single_write(7, 8'h55);
    single_write(10, 8'h77);
    do_read(7, 1'b1, 1, -1, "R3");
    do_read(10, 1'b1, 1, -1, "R3");
    single_write(3, 8'hFE);
    do_read(0, 1'b0, 7, -1, "R3");

    // R5: single transfers stop after one data byte
    wbuf[0] = 8'h41; wbuf[1] = 8'h22; wbuf[2] = 8'h07;
    do_write(1, 1'b1, 3, -1);
    do_read(0, 1'b0, 7, -1, "R5");
    do_read(0, 1'b1, 3, -1, "R5");

    // R1: command bits 1:0 ignored
    do_read(2, 1'b1, 1, -1, "R1", 2'b11);
    do_read(4, 1'b0, 3, -1, "R1", 2'b10);

    // R11: snapshot holds across a tick during a burst read
    single_write(14, 8'h20);
    load_time(8'h59, 8'h59, 8'h10, 8'h03, 8'h20, 8'h06, 8'h40);
    do_read(0, 1'b0, 7, 1, "R11");
    do_read(0, 1'b0, 7, -1, "R11");

    // R12: tick during burst write is discarded
    wbuf[0] = 8'h30; wbuf[1] = 8'h20;
    do_write(0, 1'b0, 2, 1);
    do_read(0, 1'b0, 3, -1, "R12");

    // randomized calendar scenarios
    for (int it = 0; it < 30; it++) begin
      bit h24, edge_case;
      int s, mi, h, wd, d, mo, y;
      logic c;
      h24 = 1'($urandom % 2);
      single_write(14, h24 ? 8'h20 : 8'h00);
      edge_case = 1'($urandom % 2);
      mo = 1 + int'($urandom % 12); y = int'($urandom % 100);
      c = 1'($urandom % 2); wd = int'($urandom % 7);
      s = int'($urandom % 60); mi = int'($urandom % 60); h = int'($urandom % 24);
      d = 1 + int'($urandom % mdays(mo, y));
      if (edge_case) begin
        s = 59; mi = 59; h = ($urandom % 2 == 0) ? 23 : 11;
        d = ($urandom % 2 == 0) ? mdays(mo, y) : d;
      end
      load_time(i2b(s), i2b(mi),
                h24 ? i2b(h) : (((h >= 12) ? 8'h20 : 8'h00) | i2b((h + 11) % 12 + 1)),
                8'(wd), i2b(d), {c, 2'b00, i2b(mo)[4:0]}, i2b(y));
      repeat (int'($urandom % 4)) tick_model();
      do_read(0, 1'b0, 7, -1, "R9");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule